// File: doc/BRIEF.md
# Single-Channel PWM Timer with Power-of-Two Prescaler

The block drives one PWM output from a 10-bit period counter and a 10-bit high-phase compare. A prescaler sits in front of the counter and divides the input clock by a power of two. Software programs it through two 32-bit words on a simple bus: a control word and a counter word. The control word holds the enable, single-shot, sync and prescaler exponent fields. The counter word holds the period and high-phase counts.

Software writes go into staged copies of the period, phase and exponent. The counter runs from separate active copies, which take the staged values at a period boundary, or at once while the channel is stopped. Setting the sync bit holds off this transfer. Software can then stage a complete new setting and release all three values together by clearing sync. The channel refuses to run with a zero period or a zero phase.

Top module: `pwm_timer`

## Requirements
- R1: After reset both words read zero and `pwm_o` is low.
- R2: Word 0 is the control word: bit 0 enable, bit 4 single-shot, bit 11 sync, bit 15 exponent LSB, bits 19:16 the exponent's upper four bits. Word 1 is the counter word: bits 25:16 period, bits 9:0 phase. Unused bits read zero. Writes to other addresses are ignored and reads from them return zero.
- R3: Each period count lasts 2^div input clocks, where div = {ctrl[19:16], ctrl[15]}. A div above `DIV_MAX` acts as `DIV_MAX`.
- R4: While enabled, the output is high for counts 0 to phase-1 and low from phase to period-1. A period lasts period × 2^div clocks, and the first count starts in the cycle after the enabling write.
- R5: When phase is greater than or equal to period, the output stays high for the whole period.
- R6: A write that sets enable while the active period or phase is zero leaves enable reading 0, and the output stays low.
- R7: Clearing enable drives the output low in the next cycle and zeroes the counter and the prescaler, so a later enable starts a fresh period.
- R8: With sync clear, a new period, phase or exponent written while the channel runs takes effect only at the next period boundary.
- R9: While sync is set, the active values do not change. Once sync is cleared, the staged values apply together at the next period boundary.
- R10: With single-shot set, the channel runs exactly one period, then enable clears and the output goes low.
- R11: If a zero period or zero phase becomes active at a boundary while the channel runs, enable clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the timer with `DIV_MAX` = 3 and `ADDR_W` = 2. The small prescaler ceiling means exponent saturation shows up within eight-clock ticks: an encoded exponent of 31 must behave exactly like 3. The two-bit address brings the unmapped words 2 and 3 into play for the decode checks. Periods are kept under 25 clocks, so staged-versus-active timing across period boundaries is observed cycle by cycle.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 10;
  localparam int DIV_W  = 5;

  localparam int CTRL_WORD  = 0;
  localparam int COUNT_WORD = 1;

  // control word layout
  localparam int EN_BIT      = 0;
  localparam int ONESHOT_BIT = 4;
  localparam int SYNC_BIT    = 11;
  localparam int DIV_LO_BIT  = 15;
  localparam int DIV_HI_LSB  = 16;
  // counter word layout
  localparam int PER_LSB = 16;
  localparam int PH_LSB  = 0;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] ph;
  } timing_t;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              boundary_i,
  output logic              run_o,
  output timing_t           act_o
);
  logic    en_q, en_nxt;
  logic    oneshot_q, oneshot_nxt;
  logic    sync_q, sync_nxt;
  timing_t stg_q, stg_nxt;
  timing_t act_q, act_nxt;
  logic    ctrl_wr, cnt_wr, load;
  logic    unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(CTRL_WORD));
  assign cnt_wr  = wr_en_i && (addr_i == ADDR_W'(COUNT_WORD));

  always_comb begin
    stg_nxt     = stg_q;
    sync_nxt    = sync_q;
    oneshot_nxt = oneshot_q;
    if (ctrl_wr) begin
      stg_nxt.div = {wdata_i[DIV_HI_LSB +: DIV_W-1], wdata_i[DIV_LO_BIT]};
      sync_nxt    = wdata_i[SYNC_BIT];
      oneshot_nxt = wdata_i[ONESHOT_BIT];
    end
    if (cnt_wr) begin
      stg_nxt.per = wdata_i[PER_LSB +: CNT_W];
      stg_nxt.ph  = wdata_i[PH_LSB +: CNT_W];
    end
    // commit from next-state staging so same-cycle writes are not lost
    load    = !sync_nxt && (!en_q || boundary_i);
    act_nxt = load ? stg_nxt : act_q;

    en_nxt = en_q;
    if (en_q && boundary_i &&
        (oneshot_q || act_nxt.per == '0 || act_nxt.ph == '0))
      en_nxt = 1'b0;
    if (ctrl_wr)
      en_nxt = wdata_i[EN_BIT] && (act_nxt.per != '0) && (act_nxt.ph != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      oneshot_q <= 1'b0;
      sync_q    <= 1'b0;
      stg_q     <= '0;
      act_q     <= '0;
    end else begin
      en_q      <= en_nxt;
      oneshot_q <= oneshot_nxt;
      sync_q    <= sync_nxt;
      stg_q     <= stg_nxt;
      act_q     <= act_nxt;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_WORD)) begin
      rdata_o[EN_BIT]                 = en_q;
      rdata_o[ONESHOT_BIT]            = oneshot_q;
      rdata_o[SYNC_BIT]               = sync_q;
      rdata_o[DIV_LO_BIT]             = stg_q.div[0];
      rdata_o[DIV_HI_LSB +: DIV_W-1]  = stg_q.div[DIV_W-1:1];
    end else if (addr_i == ADDR_W'(COUNT_WORD)) begin
      rdata_o[PER_LSB +: CNT_W] = stg_q.per;
      rdata_o[PH_LSB +: CNT_W]  = stg_q.ph;
    end
  end

  assign run_o = en_q;
  assign act_o = act_q;

  // R6
  run_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> (act_q.per != '0) && (act_q.ph != '0));
  // R9
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q |-> $stable(act_q));
  // R10
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && boundary_i && oneshot_q && !ctrl_wr |=> !en_q);
endmodule

// File: rtl/pwm_timer_prescaler.sv
module pwm_timer_prescaler
  import pwm_timer_pkg::*;
#(
  parameter int DIV_MAX = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PRE_W = (DIV_MAX > 0) ? DIV_MAX : 1;

  logic [DIV_W-1:0] div_eff;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] mask, pre_q;

  assign div_eff = (div_i > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : div_i;
  assign one_sh  = (PRE_W+1)'(1) << div_eff;
  assign mask    = one_sh[PRE_W-1:0] - PRE_W'(1);
  assign tick_o  = run_i && (pre_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || tick_o)  pre_q <= '0;
    else                        pre_q <= pre_q + PRE_W'(1);
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_o && (div_i != '0) |=> !tick_o || (div_i == '0));
endmodule

// File: rtl/pwm_timer_counter.sv
module pwm_timer_counter
  import pwm_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] ph_i,
  output logic             boundary_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last       = cnt_q >= (per_i - CNT_W'(1));
  assign boundary_o = tick_i && last;
  assign pwm_o      = run_i && (cnt_q < ph_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
  end

  // R4
  cnt_in_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (per_i != '0) |-> cnt_q < per_i);
  // R4
  high_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (cnt_q == '0) |-> pwm_o);
  // R7
  stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0) || run_i);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int DIV_MAX = 24,
  parameter int ADDR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              pwm_o
);
  timing_t act;
  logic    run, tick, boundary;

  pwm_timer_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .boundary_i (boundary),
    .run_o      (run),
    .act_o      (act)
  );

  pwm_timer_prescaler #(.DIV_MAX(DIV_MAX)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (act.div),
    .tick_o (tick)
  );

  pwm_timer_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick),
    .per_i      (act.per),
    .ph_i       (act.ph),
    .boundary_o (boundary),
    .pwm_o      (pwm_o)
  );

  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !pwm_o);
endmodule

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        pwm;
  int          checks = 0;
  int          fails  = 0;

  always #4 clk = ~clk;

  pwm_timer #(.DIV_MAX(3), .ADDR_W(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  typedef struct packed {
    logic [4:0]  div;
    logic [9:0]  per;
    logic [9:0]  ph;
    logic [15:0] hi;
    logic [15:0] len;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{5'd0,  10'd5, 10'd2, 16'd2, 16'd5},
    '{5'd1,  10'd4, 10'd1, 16'd2, 16'd8},
    '{5'd2,  10'd3, 10'd2, 16'd8, 16'd12},
    '{5'd0,  10'd6, 10'd9, 16'd6, 16'd6},
    '{5'd0,  10'd1, 10'd1, 16'd1, 16'd1},
    '{5'd3,  10'd3, 10'd1, 16'd8, 16'd24},
    '{5'd31, 10'd2, 10'd1, 16'd8, 16'd16},
    '{5'd0,  10'd7, 10'd6, 16'd6, 16'd7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next one
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pwm);
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] div_bits(input logic [4:0] d);
    return (32'(d >> 1) << 16) | (32'(d[0]) << 15);
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int h;
    string tag;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(2'd1, d); chk("R1 count", d, 32'h0);
    chk("R1 pwm", 32'(pwm), 32'h0);

    // R2 layout, R6 enable refused with zero active values
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 ctrl readback", d, 32'h000F_8810);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R2 count readback", d, 32'h03FF_03FF);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R2 unmapped read", d, 32'h0);
    rd(2'd1, d); chk("R2 unmapped write ignored", d, 32'h03FF_03FF);
    rd(2'd0, d); chk("R6 enable refused", d, 32'h000F_8810);
    wr(2'd0, 32'h0);

    // R3 R4 R5 waveform table
    foreach (VECS[i]) begin
      tag = (VECS[i].div > 5'd3) ? "R3" : (VECS[i].ph >= VECS[i].per) ? "R5" : "R4";
      wr(2'd0, 32'h0);
      wr(2'd1, (32'(VECS[i].per) << 16) | 32'(VECS[i].ph));
      wr(2'd0, div_bits(VECS[i].div));
      wr(2'd0, div_bits(VECS[i].div) | 32'h1);
      count_high(int'(VECS[i].len), h);
      chk({tag, " high clocks"}, 32'(h), 32'(VECS[i].hi));
      chk({tag, " next period starts high"}, 32'(pwm), 32'h1);
    end

    // R6 zero phase, then zero period
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0004_0000);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R6 zero phase", d, 32'h0);
    count_high(6, h); chk("R6 output low", 32'(h), 32'h0);
    wr(2'd1, 32'h0000_0003);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R6 zero period", d, 32'h0);

    // R7 disable mid-period, re-enable restarts
    wr(2'd1, 32'h0004_0002);
    wr(2'd0, 32'h1);
    @(negedge clk);
    wr(2'd0, 32'h0);
    chk("R7 low after disable", 32'(pwm), 32'h0);
    wr(2'd0, 32'h1);
    count_high(4, h); chk("R7 fresh period", 32'(h), 32'h2);

    // R8 running update waits for boundary
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0004_0001);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h0004_0003);
    count_high(3, h); chk("R8 old phase kept", 32'(h), 32'h0);
    count_high(4, h); chk("R8 new phase applied", 32'(h), 32'h3);

    // R9 sync staging
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0004_0001);
    wr(2'd0, 32'h1);
    wr(2'd0, 32'h801);
    wr(2'd1, 32'h0004_0003);
    rd(2'd0, d); chk("R9 enable held in sync", d, 32'h801);
    count_high(8, h); chk("R9 active frozen", 32'(h), 32'h2);
    wr(2'd0, 32'h1);
    count_high(4, h);
    count_high(8, h); chk("R9 committed on release", 32'(h), 32'h6);

    // R10 single-shot
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0003_0001);
    wr(2'd0, 32'h11);
    count_high(3, h); chk("R10 one period", 32'(h), 32'h1);
    count_high(5, h); chk("R10 stays low", 32'(h), 32'h0);
    rd(2'd0, d); chk("R10 enable cleared", d, 32'h10);

    // R11 zero period committed while running
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0004_0002);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h0000_0002);
    count_high(6, h);
    rd(2'd0, d); chk("R11 enable cleared", d, 32'h0);
    chk("R11 output low", 32'(pwm), 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule